// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block holds the working state of one DMA channel and carries out one dual-address move each time it is granted the bus. A move reads a byte or a halfword from the source offset and writes that value to the destination offset. Both offsets lie inside a fixed 64 KB window whose upper address bits are a parameter. After the write, each offset is updated by its own address mode and a 16-bit transfer counter counts down.

Software loads the channel configuration in one cycle, and an arbiter outside this block raises `grant`. The engine drives a simple synchronous memory port: read data returns in the cycle after the read strobe. It pulses `done` when the move has finished. When the counter passes below zero, the engine also pulses `underflow`, sets a sticky `irq` and reloads the counter. A halfword move to or from an odd offset is refused with an `err` pulse and does not touch memory.

Top module: `dma_chan_engine`

## Requirements
- R1: For each accepted grant, the engine drives exactly one read cycle (`mem_rd`) at the source, then exactly one write cycle (`mem_wr`) at the destination in the next cycle. The write data is the read data.
- R2: When `cfg_hw`=1 the move is a halfword and incrementing offsets step by 2. When `cfg_hw`=0 the move is a byte in bits 7:0 (bits 15:8 written as zero) and incrementing offsets step by 1. `mem_hw` shows the size during memory cycles.
- R3: The source and destination modes are independent 2-bit codes: 0 = fixed, 1 = increment, 2 = ring, 3 = fixed.
- R4: A ring-mode offset advances like increment. After every 32 transfers since the last configuration load, it returns to its loaded start value. Ring mode has no effect on `done` or `underflow`.
- R5: `mem_addr` is the window base (0x80 by default) in the upper 8 bits, with the 16-bit offset below it.
- R6: Loading count N gives N+1 transfers, so 0xFFFF gives 65,536. `underflow` pulses together with `done` of the last transfer only, and the counter then reloads N.
- R7: `irq` is set in the cycle in which `underflow` pulses. It stays set until `irq_clr` or `cfg_load`. A new underflow takes priority over the clear.
- R8: `done` is high for exactly one cycle, the cycle after the write cycle.
- R9: A grant for a halfword move with an odd source or destination offset gives a one-cycle `err` in the next cycle. It makes no memory cycle and no `done`.
- R10: `grant` is ignored while a move is in progress (`busy`=1). Holding it high across a move starts no second move.
- R11: After reset, `busy`, `done`, `err`, `underflow`, `irq`, `mem_rd` and `mem_wr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the channel configuration |
| cfg_src | input | 16 | Source start offset |
| cfg_dst | input | 16 | Destination start offset |
| cfg_cnt | input | 16 | Transfer count (N gives N+1 moves) |
| cfg_hw | input | 1 | 1 = halfword, 0 = byte |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| irq_clr | input | 1 | Clear the interrupt request |
| grant | input | 1 | Start one move when idle |
| busy | output | 1 | Move in progress |
| done | output | 1 | Move completed (one cycle) |
| err | output | 1 | Misaligned move refused (one cycle) |
| underflow | output | 1 | Counter passed below zero (one cycle) |
| irq | output | 1 | Sticky interrupt request |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_hw | output | 1 | Memory access is a halfword |
| mem_addr | output | 24 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |

## Verification
The engine is driven with several mixes of size and mode. Byte increment on both sides shows the unit step and the exact point of underflow. Halfword increment-to-fixed shows the step of two and that the counter reloads after an underflow. Byte ring source against an increment destination runs 40 moves, so the return to the start value after 32 moves is seen and is kept apart from counter completion. An odd halfword offset and a grant held across a whole move show that refused or extra requests cause no memory cycle.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int OFS_W = 16,
  parameter int CNT_W = 16,
  parameter int WIN_W = 8,
  parameter logic [WIN_W-1:0] WIN_BASE = 8'h80,
  parameter int RING_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [OFS_W-1:0]       cfg_src,
  input  logic [OFS_W-1:0]       cfg_dst,
  input  logic [CNT_W-1:0]       cfg_cnt,
  input  logic                   cfg_hw,
  input  logic [1:0]             cfg_src_mode,
  input  logic [1:0]             cfg_dst_mode,
  input  logic                   irq_clr,
  input  logic                   grant,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   underflow,
  output logic                   irq,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic                   mem_hw,
  output logic [WIN_W+OFS_W-1:0] mem_addr,
  output logic [15:0]            mem_wdata,
  input  logic [15:0]            mem_rdata
);
  localparam int RING_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_FIN, S_ERR} st_t;
  st_t state;

  logic [OFS_W-1:0]  src, dst, src0, dst0;
  logic [CNT_W-1:0]  cnt, rld;
  logic [RING_W-1:0] ring;
  logic [1:0]        smode, dmode;
  logic              hw, uf_q;

  wire [OFS_W-1:0] step  = {{(OFS_W-2){1'b0}}, hw, ~hw};
  wire             wrap  = (ring == RING_W'(RING_LEN - 1));
  wire             misal = hw & (src[0] | dst[0]);
  wire             last  = (cnt == '0);

  function automatic logic [OFS_W-1:0] next_ofs(input logic [1:0] m,
      input logic [OFS_W-1:0] a, input logic [OFS_W-1:0] a0,
      input logic [OFS_W-1:0] s, input logic w);
    case (m)
      2'd1:    next_ofs = a + s;
      2'd2:    next_ofs = w ? a0 : a + s;
      default: next_ofs = a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      src <= '0; dst <= '0; src0 <= '0; dst0 <= '0;
      cnt <= '0; rld <= '0; ring <= '0;
      smode <= 2'd0; dmode <= 2'd0; hw <= 1'b0;
      uf_q <= 1'b0; irq <= 1'b0;
    end else begin
      uf_q <= (state == S_WR) && last;
      case (state)
        S_IDLE: if (grant) state <= misal ? S_ERR : S_RD;
        S_RD:   state <= S_WR;
        S_WR: begin
          state <= S_FIN;
          src   <= next_ofs(smode, src, src0, step, wrap);
          dst   <= next_ofs(dmode, dst, dst0, step, wrap);
          ring  <= wrap ? '0 : ring + 1'b1;
          cnt   <= last ? rld : cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
      if ((state == S_WR) && last) irq <= 1'b1;
      else if (cfg_load || irq_clr) irq <= 1'b0;
      if (cfg_load) begin
        src <= cfg_src; dst <= cfg_dst; src0 <= cfg_src; dst0 <= cfg_dst;
        cnt <= cfg_cnt; rld <= cfg_cnt; ring <= '0;
        smode <= cfg_src_mode; dmode <= cfg_dst_mode; hw <= cfg_hw;
      end
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);
  assign err       = (state == S_ERR);
  assign underflow = uf_q;
  assign mem_rd    = (state == S_RD);
  assign mem_wr    = (state == S_WR);
  assign mem_hw    = hw;
  assign mem_addr  = {WIN_BASE, (state == S_WR) ? dst : src};
  assign mem_wdata = hw ? mem_rdata : {8'h00, mem_rdata[7:0]};

  a_r1_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_wr && !mem_rd);
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done && !mem_wr);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_uf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> done);
  a_r7_irq_follows_uf: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> irq);
  a_r9_err_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !mem_rd && !mem_wr && !done);
  a_r10_busy_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !err) |=> busy);
endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 0, cfg_hw = 0, irq_clr = 0, grant = 0;
  logic [15:0] cfg_src = 0, cfg_dst = 0, cfg_cnt = 0;
  logic [1:0] cfg_src_mode = 0, cfg_dst_mode = 0;
  logic busy, done, err, underflow, irq, mem_rd, mem_wr, mem_hw;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  int total = 0, bad = 0;
  logic [7:0] ram [4096];
  logic [39:0] expq [$];

  logic [15:0] m_src, m_dst, m_src0, m_dst0, m_cnt, m_rld;
  logic [1:0] m_sm, m_dm;
  logic m_hw;
  int m_ring;

  always #2.5 clk = ~clk;

  dma_chan_engine uut (.*);

  always_ff @(posedge clk) begin
    if (mem_rd)
      mem_rdata <= mem_hw ? {ram[mem_addr[11:0] + 12'd1], ram[mem_addr[11:0]]}
                          : {8'h00, ram[mem_addr[11:0]]};
    if (mem_wr) begin
      ram[mem_addr[11:0]] <= mem_wdata[7:0];
      if (mem_hw) ram[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && mem_wr) begin
    logic [39:0] e;
    if (expq.size() == 0) chk(0, "R1 unexpected write", {mem_addr, mem_wdata}, 40'h0);
    else begin
      e = expq.pop_front();
      chk({mem_addr, mem_wdata} == e, "R1/R2/R3/R5 write addr+data", {mem_addr, mem_wdata}, e);
    end
  end

  function automatic logic [15:0] nxt(input logic [1:0] m, input logic [15:0] a, input logic [15:0] a0, input bit w);
    logic [15:0] s = m_hw ? 16'd2 : 16'd1;
    if (m == 2'd1) return a + s;
    if (m == 2'd2) return w ? a0 : a + s;
    return a;
  endfunction

  task automatic load(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                      input bit h, input logic [1:0] sm, input logic [1:0] dm);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_hw = h;
    cfg_src_mode = sm; cfg_dst_mode = dm; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    m_src = s; m_dst = d; m_src0 = s; m_dst0 = d; m_cnt = c; m_rld = c;
    m_hw = h; m_sm = sm; m_dm = dm; m_ring = 0;
  endtask

  task automatic xfer(input bit hold);
    logic [15:0] data;
    bit uf, w;
    data = m_hw ? {ram[m_src[11:0] + 12'd1], ram[m_src[11:0]]} : {8'h00, ram[m_src[11:0]]};
    expq.push_back({8'h80, m_dst, data});
    uf = (m_cnt == 0);
    grant = 1;
    @(negedge clk);
    if (!hold) grant = 0;
    chk(mem_rd && mem_addr == {8'h80, m_src}, "R1/R4/R5 read addr", {mem_rd, mem_addr}, {1'b1, 8'h80, m_src});
    chk(mem_hw == m_hw, "R2 size", mem_hw, m_hw);
    @(negedge clk);
    @(negedge clk);
    grant = 0;
    chk(done && !mem_wr, "R8 done after write", done, 1);
    chk(underflow == uf, "R6 underflow", underflow, uf);
    if (uf) chk(irq, "R7 irq set", irq, 1);
    @(negedge clk);
    chk(!done && !busy && !mem_rd, "R8/R10 single move", {done, busy, mem_rd}, 0);
    w = (m_ring == 31);
    m_src = nxt(m_sm, m_src, m_src0, w);
    m_dst = nxt(m_dm, m_dst, m_dst0, w);
    m_ring = w ? 0 : m_ring + 1;
    m_cnt = uf ? m_rld : m_cnt - 16'd1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) ram[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk({busy, done, err, underflow, irq, mem_rd, mem_wr} == 0, "R11 reset state",
        {busy, done, err, underflow, irq, mem_rd, mem_wr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({busy, done, err, underflow, irq, mem_rd, mem_wr} == 0, "R11 idle after reset",
        {busy, done, err, underflow, irq, mem_rd, mem_wr}, 0);

    load(16'h0100, 16'h0200, 16'd3, 0, 2'd1, 2'd1);
    for (int i = 0; i < 4; i++) xfer(0);
    chk(irq, "R7 irq sticky", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    chk(!irq, "R7 irq cleared", irq, 0);

    load(16'h0300, 16'h0400, 16'd1, 1, 2'd1, 2'd3);
    xfer(1);
    xfer(0);
    xfer(1);
    xfer(0);

    load(16'h0500, 16'h0600, 16'd39, 0, 2'd2, 2'd1);
    for (int i = 0; i < 40; i++) xfer(0);

    load(16'h0701, 16'h0800, 16'd0, 1, 2'd1, 2'd1);
    grant = 1;
    @(negedge clk);
    grant = 0;
    chk(err && !mem_rd && !mem_wr && !done, "R9 misaligned refused", {err, mem_rd, mem_wr, done}, 4'b1000);
    @(negedge clk);
    chk(!err && !busy && !mem_rd, "R9 err one cycle", {err, busy, mem_rd}, 0);
    chk(expq.size() == 0, "R1 all writes seen", expq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule